// File: doc/BRIEF.md
# Flash-Capable Discrete Bank Latch

This block is the banking controller of a cartridge that sits on an 8-bit CPU bus. It holds one 8-bit register, the bank latch, which the CPU loads by writing anywhere in the upper half of its address space. Three fields of the latch drive the cartridge:

- a 16 KB program bank number for the switchable lower window;
- a bank number for the 8 KB character RAM;
- a choice between two single-screen nametable layouts.

The upper program window always shows the last 16 KB bank. The block also forms the program ROM address for the current CPU address, without a register on the way.

A configuration input, `flash_mode`, picks one of two behaviours:

- **Mask ROM mode.** Every write to 0x8000–0xFFFF loads the latch. The latch models a bus conflict: it takes the CPU data ANDed with the ROM byte presented at that address.
- **Flash mode.** Writes to the lower window are not register loads. They are passed as one-cycle commands to a flash command port, together with the low address bits and the current value of latch bit 0. Only writes to the upper window load the latch, and those loads are not masked.

Top module: `flash_bank_latch`

## Requirements
- R1: During a cycle with `rst_n` low, the latch clears to zero on the clock edge. After that edge `prg_bank`, `chr_bank` and `mirror_sel` read zero and `fcmd_valid` is low.
- R2: `prg_bank` equals latch bits 4:0. While `cpu_a[15:14]` is 2'b10, `rom_addr` equals {`prg_bank`, `cpu_a[13:0]`}, combinationally.
- R3: While `cpu_a[15:14]` is 2'b11, `rom_addr` equals {5'b11111, `cpu_a[13:0]`}, whatever the latch holds.
- R4: `chr_bank` equals latch bits 6:5.
- R5: `mirror_sel` equals latch bit 7. A value of 0 selects screen 0 and a value of 1 selects screen 1.
- R6: With `flash_mode` low, a write strobe at an address with `cpu_a[15]` = 1 loads the latch with `cpu_d & rom_rd_data`. The outputs show the new value one clock later.
- R7: A write strobe with `cpu_a[15]` = 0 changes neither the latch nor the flash command port, in either mode.
- R8: With `flash_mode` high, a write with `cpu_a[15:14]` = 2'b10 leaves the latch unchanged. One clock later it raises `fcmd_valid` for exactly one cycle. In that cycle:
  - `fcmd_addr` holds `cpu_a[13:0]`;
  - `fcmd_bank0` holds latch bit 0 as it was at the write;
  - `fcmd_data` holds `cpu_d`.
- R9: With `flash_mode` high, a write with `cpu_a[15:14]` = 2'b11 loads the latch with `cpu_d` unmasked. The outputs show the new value one clock later.
- R10: With `flash_mode` low, `fcmd_valid` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flash_mode | input | 1 | 1 selects flash mode, 0 selects mask ROM mode |
| cpu_wr | input | 1 | One-cycle CPU write strobe |
| cpu_a | input | 16 | CPU address |
| cpu_d | input | 8 | CPU write data |
| rom_rd_data | input | 8 | ROM byte at `cpu_a`, valid together with `cpu_wr` |
| prg_bank | output | 5 | Program bank for the lower window |
| chr_bank | output | 2 | Character RAM 8 KB bank |
| mirror_sel | output | 1 | Single-screen nametable select |
| rom_addr | output | 19 | Program ROM address for `cpu_a` |
| fcmd_valid | output | 1 | Flash command strobe, one cycle |
| fcmd_addr | output | 14 | Flash command address, `cpu_a[13:0]` |
| fcmd_bank0 | output | 1 | Latch bit 0 captured with the command |
| fcmd_data | output | 8 | Flash command data |

## Verification
The latch is loaded with several distinct patterns:
- all ones;
- a byte where the ROM mask clears some bits but not others, which separates a masked load from a plain load;
- values that move each field independently.

In flash mode, the bench interleaves lower-window command writes with upper-window loads. It checks that commands leave the latch untouched, that the captured bank bit follows the latch value at the moment of each write, and that upper-window loads ignore a zero ROM byte. Writes below 0x8000 in both modes, and lower-window writes after returning to mask ROM mode, separate the address decode from the mode decode. The ROM address is compared in both windows, for a bank that is not all ones.

// File: rtl/flash_bank_latch_pkg.sv
// Package: shared widths, latch field layout and write classification
// for the flash-capable bank latch.
package flash_bank_latch_pkg;
    parameter int PRG_W = 5;   // program bank number width
    parameter int CHR_W = 2;   // character RAM bank number width
    parameter int WIN_W = 14;  // address bits inside one 16 KB window

    localparam int LATCH_W = PRG_W + CHR_W + 1;
    localparam int AW      = WIN_W + 2;
    localparam int ROMA_W  = PRG_W + WIN_W;

    // Latch layout, most significant field first: screen select, chr bank, prg bank
    typedef struct packed {
        logic             screen;
        logic [CHR_W-1:0] chr;
        logic [PRG_W-1:0] prg;
    } latch_t;

    // What a single CPU write does to the block
    typedef enum logic [1:0] {
        WR_NONE   = 2'd0,
        WR_MASKED = 2'd1,
        WR_DIRECT = 2'd2,
        WR_FLASH  = 2'd3
    } wr_kind_e;
endpackage

// File: rtl/fbl_write_decode.sv
// Module: fbl_write_decode
// Classifies a CPU write from its top two address bits and the mode input.
// Assumes the write strobe lasts one cycle and the address is stable with it.
module fbl_write_decode
    import flash_bank_latch_pkg::*;
(
    input  logic     wr,
    input  logic     flash_mode,
    input  logic     a_top,    // address bit 15
    input  logic     a_win,    // address bit 14: 0 lower window, 1 upper window
    output wr_kind_e kind
);
    // Mode and window pick the destination of the write
    always_comb begin
        kind = WR_NONE;
        if (wr && a_top) begin
            if (!flash_mode)
                kind = WR_MASKED;
            else if (a_win)
                kind = WR_DIRECT;
            else
                kind = WR_FLASH;
        end
    end
endmodule

// File: rtl/fbl_latch_reg.sv
// Module: fbl_latch_reg
// The bank latch register. A masked load takes data AND rom byte, a direct
// load takes the data unchanged, anything else holds.
// Assumes rom_d belongs to the same cycle as the write classification.
module fbl_latch_reg
    import flash_bank_latch_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  wr_kind_e           kind,
    input  logic [LATCH_W-1:0] cpu_d,
    input  logic [LATCH_W-1:0] rom_d,
    output latch_t             q
);
    // Latch update with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (kind == WR_MASKED)
            q <= latch_t'(cpu_d & rom_d);
        else if (kind == WR_DIRECT)
            q <= latch_t'(cpu_d);
    end

    // R8
    flash_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == WR_FLASH) |=> $stable(q));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (q == '0));
endmodule

// File: rtl/fbl_flash_port.sv
// Module: fbl_flash_port
// Registers a lower-window flash-mode write into a one-cycle command strobe
// with its address, data and the latch bank bit sampled at the write.
module fbl_flash_port
    import flash_bank_latch_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  wr_kind_e           kind,
    input  logic [WIN_W-1:0]   a_low,
    input  logic               bank0,
    input  logic [LATCH_W-1:0] cpu_d,
    output logic               valid,
    output logic [WIN_W-1:0]   addr,
    output logic               bank0_q,
    output logic [LATCH_W-1:0] data
);
    // Strobe generation: high for one cycle per command write
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid <= 1'b0;
        else
            valid <= (kind == WR_FLASH);
    end

    // Command payload capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr    <= '0;
            bank0_q <= 1'b0;
            data    <= '0;
        end else if (kind == WR_FLASH) begin
            addr    <= a_low;
            bank0_q <= bank0;
            data    <= cpu_d;
        end
    end

    // R8
    payload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != WR_FLASH) |=> ($stable(addr) && $stable(data) && $stable(bank0_q)));
endmodule

// File: rtl/fbl_addr_map.sv
// Module: fbl_addr_map
// Forms the program ROM address. The upper window forces the bank to all
// ones (last bank); the lower window uses the latch bank. Purely combinational.
module fbl_addr_map
    import flash_bank_latch_pkg::*;
(
    input  logic [PRG_W-1:0]  prg,
    input  logic [WIN_W:0]    a,        // window select bit on top of the offset
    output logic [ROMA_W-1:0] rom_addr
);
    logic [PRG_W-1:0] bank;

    // Window select chooses fixed or switched bank
    always_comb begin
        bank     = a[WIN_W] ? {PRG_W{1'b1}} : prg;
        rom_addr = {bank, a[WIN_W-1:0]};
    end
endmodule

// File: rtl/flash_bank_latch.sv
// Module: flash_bank_latch (top)
// Single-latch cartridge banking with an optional flash command path.
// Assumes: one-cycle cpu_wr strobes, rom_rd_data valid with the strobe,
// flash_mode changed only between writes.
module flash_bank_latch
    import flash_bank_latch_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flash_mode,
    input  logic                  cpu_wr,
    input  logic [AW-1:0]         cpu_a,
    input  logic [LATCH_W-1:0]    cpu_d,
    input  logic [LATCH_W-1:0]    rom_rd_data,
    output logic [PRG_W-1:0]      prg_bank,
    output logic [CHR_W-1:0]      chr_bank,
    output logic                  mirror_sel,
    output logic [ROMA_W-1:0]     rom_addr,
    output logic                  fcmd_valid,
    output logic [WIN_W-1:0]      fcmd_addr,
    output logic                  fcmd_bank0,
    output logic [LATCH_W-1:0]    fcmd_data
);
    wr_kind_e kind;
    latch_t   latch_q;

    fbl_write_decode u_decode (
        .wr         (cpu_wr),
        .flash_mode (flash_mode),
        .a_top      (cpu_a[AW-1]),
        .a_win      (cpu_a[AW-2]),
        .kind       (kind)
    );

    fbl_latch_reg u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .kind  (kind),
        .cpu_d (cpu_d),
        .rom_d (rom_rd_data),
        .q     (latch_q)
    );

    fbl_flash_port u_fport (
        .clk     (clk),
        .rst_n   (rst_n),
        .kind    (kind),
        .a_low   (cpu_a[WIN_W-1:0]),
        .bank0   (latch_q.prg[0]),
        .cpu_d   (cpu_d),
        .valid   (fcmd_valid),
        .addr    (fcmd_addr),
        .bank0_q (fcmd_bank0),
        .data    (fcmd_data)
    );

    fbl_addr_map u_amap (
        .prg      (latch_q.prg),
        .a        (cpu_a[WIN_W:0]),
        .rom_addr (rom_addr)
    );

    // Field outputs straight from the latch
    always_comb begin
        prg_bank   = latch_q.prg;
        chr_bank   = latch_q.chr;
        mirror_sel = latch_q.screen;
    end

    // R6
    masked_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_a[AW-1] && !flash_mode)
        |=> ({mirror_sel, chr_bank, prg_bank} == $past(cpu_d & rom_rd_data)));

    // R9
    direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_a[AW-1] && cpu_a[AW-2] && flash_mode)
        |=> ({mirror_sel, chr_bank, prg_bank} == $past(cpu_d)));

    // R7
    low_space_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_a[AW-1])
        |=> ($stable({mirror_sel, chr_bank, prg_bank}) && !fcmd_valid));

    // R10
    rom_mode_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_mode |=> !fcmd_valid);

    // R3
    upper_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_a[AW-1:AW-2] == 2'b11) |-> (rom_addr[ROMA_W-1:WIN_W] == {PRG_W{1'b1}}));
endmodule

// File: tb/flash_bank_latch_tb.sv
// Scoreboard bench: a driver task models each write and queues the expected
// result; a monitor pops and compares after the clock edge that applies it.
module flash_bank_latch_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flash_mode = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_a = '0;
    logic [7:0]  cpu_d = '0;
    logic [7:0]  rom_rd_data = '0;
    logic [4:0]  prg_bank;
    logic [1:0]  chr_bank;
    logic        mirror_sel;
    logic [18:0] rom_addr;
    logic        fcmd_valid;
    logic [13:0] fcmd_addr;
    logic        fcmd_bank0;
    logic [7:0]  fcmd_data;

    int checks = 0;
    int errors = 0;

    typedef struct packed {
        logic [7:0]  latch;
        logic        fv;
        logic [13:0] fa;
        logic        fh;
        logic [7:0]  fd;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    logic [7:0] m_latch = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_bank_latch u_dut (
        .clk(clk), .rst_n(rst_n), .flash_mode(flash_mode), .cpu_wr(cpu_wr),
        .cpu_a(cpu_a), .cpu_d(cpu_d), .rom_rd_data(rom_rd_data),
        .prg_bank(prg_bank), .chr_bank(chr_bank), .mirror_sel(mirror_sel),
        .rom_addr(rom_addr), .fcmd_valid(fcmd_valid), .fcmd_addr(fcmd_addr),
        .fcmd_bank0(fcmd_bank0), .fcmd_data(fcmd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: model the write, queue the expectation, strobe for one cycle
    task automatic do_write(input logic [15:0] a, input logic [7:0] d,
                            input logic [7:0] rom, input string tag);
        exp_t e;
        e = '0;
        if (a[15]) begin
            if (!flash_mode)
                m_latch = d & rom;
            else if (a[14])
                m_latch = d;
            else begin
                e.fv = 1'b1;
                e.fa = a[13:0];
                e.fh = m_latch[0];
                e.fd = d;
            end
        end
        e.latch = m_latch;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        cpu_a = a; cpu_d = d; rom_rd_data = rom; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: compare after the edge that consumed a write; idle cycles expect no strobe
    always @(posedge clk) begin
        logic  wr_seen;
        logic  live;
        exp_t  e;
        string t;
        wr_seen = cpu_wr;
        live    = rst_n;
        #2;
        if (live) begin
            if (wr_seen) begin
                if (exp_q.size() == 0) begin
                    chk("scoreboard underflow", 32'd1, 32'd0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk({t, " prg_bank (R2)"}, 32'(prg_bank), 32'(e.latch[4:0]));
                    chk({t, " chr_bank (R4)"}, 32'(chr_bank), 32'(e.latch[6:5]));
                    chk({t, " mirror_sel (R5)"}, 32'(mirror_sel), 32'(e.latch[7]));
                    chk({t, " fcmd_valid"}, 32'(fcmd_valid), 32'(e.fv));
                    if (e.fv) begin
                        chk({t, " fcmd_addr R8"}, 32'(fcmd_addr), 32'(e.fa));
                        chk({t, " fcmd_bank0 R8"}, 32'(fcmd_bank0), 32'(e.fh));
                        chk({t, " fcmd_data R8"}, 32'(fcmd_data), 32'(e.fd));
                    end
                end
            end else begin
                chk("R8 strobe one cycle / idle", 32'(fcmd_valid), 32'd0);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 prg_bank", 32'(prg_bank), 32'd0);
        chk("R1 chr_bank", 32'(chr_bank), 32'd0);
        chk("R1 mirror_sel", 32'(mirror_sel), 32'd0);
        chk("R1 fcmd_valid", 32'(fcmd_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Mask ROM mode
        do_write(16'h8000, 8'hFF, 8'hFF, "R6 all ones");
        do_write(16'hC123, 8'hF7, 8'h3C, "R6 masked load");
        do_write(16'h7FFF, 8'hAA, 8'hFF, "R7 low write rom mode");
        do_write(16'hA000, 8'h85, 8'hFF, "R6 field split");

        // R2 / R3: address former with bank 5
        cpu_a = 16'h8ABC; #1;
        chk("R2 lower rom_addr", 32'(rom_addr), 32'({5'h05, 14'h0ABC}));
        cpu_a = 16'hFABC; #1;
        chk("R3 upper rom_addr", 32'(rom_addr), 32'({5'h1F, 14'h3ABC}));
        @(negedge clk);

        // Flash mode
        flash_mode = 1'b1;
        @(negedge clk);
        do_write(16'h9555, 8'hAA, 8'h00, "R8 cmd bank bit 1");
        do_write(16'hAAAA, 8'h55, 8'h00, "R8 second cmd");
        do_write(16'hE000, 8'h42, 8'h00, "R9 direct load");
        do_write(16'h9555, 8'hA0, 8'h00, "R8 cmd bank bit 0");
        do_write(16'h1234, 8'h99, 8'hFF, "R7 low write flash mode");
        cpu_a = 16'hC000; #1;
        chk("R3 upper rom_addr flash mode", 32'(rom_addr), 32'({5'h1F, 14'h0000}));
        cpu_a = 16'hB001; #1;
        chk("R2 lower rom_addr bank 2", 32'(rom_addr), 32'({5'h02, 14'h3001}));
        @(negedge clk);

        // Back to mask ROM mode
        flash_mode = 1'b0;
        @(negedge clk);
        do_write(16'h9555, 8'hAA, 8'hFF, "R10 lower write loads latch");
        do_write(16'h8000, 8'h0F, 8'hF3, "R10 masked again");

        repeat (3) @(negedge clk);
        chk("scoreboard drained", 32'(exp_q.size()), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule